// File: doc/BRIEF.md
# Instruction-Granular Accumulator Core

This block executes a small eight-opcode accumulator instruction set one whole instruction at a time. Each step it fetches a word from an external word-addressed memory at the program counter. It works out the architectural effect on the program counter, the accumulator and memory. It then holds that effect back until a fixed, opcode-dependent number of cycles has elapsed, and commits it in a single cycle. The timing reproduces the cycle profile of a multi-step implementation of the same instruction set. Because of this, the block can run in lockstep beside such an implementation as a synthesizable golden model. Comparing the two at each commit pulse catches any architectural divergence.

An instruction word is `ADDR_W + 3` bits wide. The top three bits carry the opcode and the low `ADDR_W` bits carry a memory address. The memory is reached through one read port with combinational read data and one write strobe. The address port shows the program counter during the fetch cycle and the instruction's address field for the rest of the instruction.

Top module: `acc_core`

## Requirements
- R1: While `rst_n` is low at a clock edge, the program counter and accumulator clear to 0 and `commit_o` is 0. The first instruction after reset is fetched from address 0, and its commit is timed from the first clock edge with `rst_n` high.
- R2: The instruction word is the memory word at the program counter modulo 2^ADDR_W. The opcode is bits [ADDR_W+2:ADDR_W] and the address field is bits [ADDR_W-1:0].
- R3: Opcode 0 is a conditional branch. If the accumulator is zero, the program counter becomes the entire instruction word and the latency is 5. Otherwise the program counter increments and the latency is 6.
- R4: Opcode 1 is an unconditional branch. The program counter becomes the entire instruction word, the accumulator is unchanged, and the latency is 4.
- R5: Opcode 2 adds the memory word at the address field to the accumulator, and opcode 3 subtracts it from the accumulator. Both work modulo 2^(ADDR_W+3), increment the program counter, and have a latency of 8.
- R6: Opcode 4 loads the accumulator from the memory word at the address field, increments the program counter, and has a latency of 6.
- R7: Opcode 5 writes the accumulator to the memory word at the address field with exactly one write strobe, in the cycle before the commit pulse. The accumulator is unchanged, the program counter increments, and the latency is 6.
- R8: Opcodes 6 and 7 change only the program counter, which increments. Their latencies are 6 and 5.
- R9: The program counter increments modulo 2^(ADDR_W+3), so 0xFF steps to 0x00 at the default width. During the fetch cycle the memory address port shows the low ADDR_W bits of the program counter.
- R10: `commit_o` is a one-cycle pulse in the first cycle that shows the new program counter and accumulator. Those two outputs change at no other time. Latency is the number of clock edges from one commit pulse, or from reset release, to the next commit pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_addr_o | output | ADDR_W | Memory word address: fetch address, then operand address |
| mem_rdata_i | input | ADDR_W+3 | Combinational read data for `mem_addr_o` |
| mem_we_o | output | 1 | Write strobe for a store, taken at the next clock edge |
| mem_wdata_o | output | ADDR_W+3 | Write data (the accumulator) |
| commit_o | output | 1 | One-cycle pulse when an instruction's effect becomes visible |
| pc_o | output | ADDR_W+3 | Architectural program counter |
| acc_o | output | ADDR_W+3 | Architectural accumulator |

## Verification
A wrong latched instruction, a wrong operand or a wrong execute result shows up at the very next commit pulse, as a wrong `pc_o` or `acc_o` or as a wrong memory word. That pulse is at most eight cycles after the fault. A countdown loaded with the wrong value, or a branch decision taken on the wrong condition, shows up as a wrong gap between commit pulses. A stuck timer shows up as a missing pulse. The bench measures every gap and compares both architectural outputs at each pulse, so a fault is seen within one instruction. The pulse-to-pulse wrap test exposes a program counter that is too narrow, and an address port that mixes up fetch and operand addresses.

// File: rtl/acc_core_pkg.sv
// Shared opcode encoding and per-opcode commit latencies for the
// accumulator core. Assumes a 3-bit opcode field above the address field.
package acc_core_pkg;

    typedef enum logic [2:0] {
        OPC_BZ    = 3'd0,
        OPC_BR    = 3'd1,
        OPC_ADD   = 3'd2,
        OPC_SUB   = 3'd3,
        OPC_LDA   = 3'd4,
        OPC_STA   = 3'd5,
        OPC_IDLE6 = 3'd6,
        OPC_IDLE7 = 3'd7
    } opc_e;

    localparam int OPC_W        = 3;
    localparam int LAT_BZ_TAKEN = 5;
    localparam int LAT_BZ_FALL  = 6;
    localparam int LAT_BR       = 4;
    localparam int LAT_ARITH    = 8;
    localparam int LAT_MEMOP    = 6;
    localparam int LAT_IDLE6    = 6;
    localparam int LAT_IDLE7    = 5;
    localparam int LAT_MAX      = 8;
    // Counter holds latency minus 2 (fetch cycle and commit cycle excluded).
    localparam int CNT_W        = $clog2(LAT_MAX - 1);

endpackage

// File: rtl/acc_core_latency.sv
// Maps a freshly fetched opcode to its countdown preload (latency - 2).
// Assumes the accumulator seen at fetch is the one the instruction uses.
module acc_core_latency
    import acc_core_pkg::*;
(
    input  opc_e             opc_i,
    input  logic             acc_zero_i,
    output logic [CNT_W-1:0] preload_o
);

    int lat;

    // Select the commit latency of the opcode.
    always_comb begin
        unique case (opc_i)
            OPC_BZ:           lat = acc_zero_i ? LAT_BZ_TAKEN : LAT_BZ_FALL;
            OPC_BR:           lat = LAT_BR;
            OPC_ADD, OPC_SUB: lat = LAT_ARITH;
            OPC_LDA, OPC_STA: lat = LAT_MEMOP;
            OPC_IDLE6:        lat = LAT_IDLE6;
            default:          lat = LAT_IDLE7;
        endcase
        preload_o = CNT_W'(lat - 2);
    end

endmodule

// File: rtl/acc_core_exec.sv
// Computes the architectural effect of one instruction from the latched
// word, the current state and the operand read at the address field.
// Purely combinational; used only in the commit cycle.
module acc_core_exec
    import acc_core_pkg::*;
#(
    parameter  int ADDR_W = 5,
    localparam int WORD_W = ADDR_W + OPC_W
) (
    input  logic [WORD_W-1:0] ir_i,
    input  logic [WORD_W-1:0] pc_i,
    input  logic [WORD_W-1:0] acc_i,
    input  logic [WORD_W-1:0] operand_i,
    output logic [WORD_W-1:0] pc_next_o,
    output logic [WORD_W-1:0] acc_next_o,
    output logic              store_o
);

    opc_e              opc;
    logic [WORD_W-1:0] pc_step;

    // Decode the opcode and form the wrapped sequential successor.
    always_comb begin
        opc     = opc_e'(ir_i[WORD_W-1:ADDR_W]);
        pc_step = pc_i + WORD_W'(1);
    end

    // Select next program counter, next accumulator and store request.
    always_comb begin
        pc_next_o  = pc_step;
        acc_next_o = acc_i;
        store_o    = 1'b0;
        unique case (opc)
            OPC_BZ:  pc_next_o  = (acc_i == '0) ? ir_i : pc_step;
            OPC_BR:  pc_next_o  = ir_i;
            OPC_ADD: acc_next_o = acc_i + operand_i;
            OPC_SUB: acc_next_o = acc_i - operand_i;
            OPC_LDA: acc_next_o = operand_i;
            OPC_STA: store_o    = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/acc_core_timer.sv
// Instruction phase tracker: idle means fetch this cycle, busy means
// counting down. Expires in the cycle the counter is zero while busy.
module acc_core_timer
    import acc_core_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] preload_i,
    output logic             busy_o,
    output logic             expire_o
);

    logic [CNT_W-1:0] cnt;

    // Load on fetch, count down while busy, drop back to fetch on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o <= 1'b0;
            cnt    <= '0;
        end else if (!busy_o) begin
            busy_o <= 1'b1;
            cnt    <= preload_i;
        end else if (cnt == '0) begin
            busy_o <= 1'b0;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    // Flag the commit cycle.
    always_comb expire_o = busy_o && (cnt == '0);

endmodule

// File: rtl/acc_core.sv
// Instruction-granular accumulator core. Fetches at the program counter,
// holds the instruction for its opcode latency, reads the operand and
// commits program counter, accumulator and any store in the last cycle.
// Assumes memory read data is combinational on mem_addr_o.
module acc_core
    import acc_core_pkg::*;
#(
    parameter  int ADDR_W = 5,
    localparam int WORD_W = ADDR_W + OPC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic [WORD_W-1:0] mem_rdata_i,
    output logic              mem_we_o,
    output logic [WORD_W-1:0] mem_wdata_o,
    output logic              commit_o,
    output logic [WORD_W-1:0] pc_o,
    output logic [WORD_W-1:0] acc_o
);

    logic [WORD_W-1:0] ir;
    logic [CNT_W-1:0]  preload;
    logic              busy;
    logic              expire;
    logic [WORD_W-1:0] pc_next;
    logic [WORD_W-1:0] acc_next;
    logic              store_req;

    acc_core_latency u_lat (
        .opc_i      (opc_e'(mem_rdata_i[WORD_W-1:ADDR_W])),
        .acc_zero_i (acc_o == '0),
        .preload_o  (preload)
    );

    acc_core_timer u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .preload_i (preload),
        .busy_o    (busy),
        .expire_o  (expire)
    );

    acc_core_exec #(.ADDR_W(ADDR_W)) u_exe (
        .ir_i       (ir),
        .pc_i       (pc_o),
        .acc_i      (acc_o),
        .operand_i  (mem_rdata_i),
        .pc_next_o  (pc_next),
        .acc_next_o (acc_next),
        .store_o    (store_req)
    );

    // Address mux: program counter while fetching, address field after.
    always_comb begin
        mem_addr_o  = busy ? ir[ADDR_W-1:0] : pc_o[ADDR_W-1:0];
        mem_we_o    = expire && store_req;
        mem_wdata_o = acc_o;
    end

    // Latch the instruction word in the fetch cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)     ir <= '0;
        else if (!busy) ir <= mem_rdata_i;
    end

    // Commit architectural state and raise the pulse alongside it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_o     <= '0;
            acc_o    <= '0;
            commit_o <= 1'b0;
        end else begin
            commit_o <= expire;
            if (expire) begin
                pc_o  <= pc_next;
                acc_o <= acc_next;
            end
        end
    end

endmodule

// File: rtl/acc_core_checker.sv
// Temporal checks on the core's ports, bound into every acc_core instance.
// Assumes reset is held for at least one clock edge before release.
module acc_core_checker #(
    parameter int WORD_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              commit_o,
    input logic              mem_we_o,
    input logic [WORD_W-1:0] pc_o,
    input logic [WORD_W-1:0] acc_o
);

    logic       armed;
    logic [3:0] gap;

    // Track whether the previous sample was out of reset.
    always_ff @(posedge clk) armed <= rst_n;

    // Count edges since reset or the last commit, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)        gap <= 4'd0;
        else if (commit_o) gap <= 4'd1;
        else if (gap != 4'd15) gap <= gap + 4'd1;
    end

    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> !commit_o);

    a_r10_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !commit_o) |-> $stable(pc_o));

    a_r10_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !commit_o) |-> $stable(acc_o));

    a_r10_gap_legal: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> (gap == 4'd4 || gap == 4'd5 || gap == 4'd6 || gap == 4'd8));

    a_r10_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_o |-> (gap < 4'd8));

    a_r7_store_then_commit: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |=> commit_o);

    a_r7_single_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |=> !mem_we_o);

endmodule

bind acc_core acc_core_checker #(.WORD_W(WORD_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .commit_o (commit_o),
    .mem_we_o (mem_we_o),
    .pc_o     (pc_o),
    .acc_o    (acc_o)
);

// File: tb/acc_core_tb_top.sv
// Self-checking bench: vector table of single instructions, then directed
// reset, wrap and mid-instruction reset tests.
module acc_core_tb_top;

    localparam int AW = 5;
    localparam int DW = AW + 3;
    localparam logic [AW-1:0] OPND = 5'd10;
    localparam logic [AW-1:0] PRE  = 5'd30;

    // {opc[3], pre_acc[8], operand[8], exp_pc[8], exp_acc[8], exp_lat[4], exp_mem[8]}
    localparam int NV = 9;
    localparam logic [46:0] VEC [NV] = '{
        {3'd0, 8'h00, 8'h00, 8'h0A, 8'h00, 4'd5, 8'h00},
        {3'd0, 8'h05, 8'h00, 8'h02, 8'h05, 4'd6, 8'h00},
        {3'd1, 8'h07, 8'h11, 8'h2A, 8'h07, 4'd4, 8'h11},
        {3'd2, 8'hF0, 8'h25, 8'h02, 8'h15, 4'd8, 8'h25},
        {3'd3, 8'h10, 8'h20, 8'h02, 8'hF0, 4'd8, 8'h20},
        {3'd4, 8'h33, 8'hC4, 8'h02, 8'hC4, 4'd6, 8'hC4},
        {3'd5, 8'h5A, 8'h00, 8'h02, 8'h5A, 4'd6, 8'h5A},
        {3'd6, 8'h77, 8'h44, 8'h02, 8'h77, 4'd6, 8'h44},
        {3'd7, 8'h77, 8'h44, 8'h02, 8'h77, 4'd5, 8'h44}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] mem_addr_o;
    logic [DW-1:0] mem_rdata_i;
    logic          mem_we_o;
    logic [DW-1:0] mem_wdata_o;
    logic          commit_o;
    logic [DW-1:0] pc_o;
    logic [DW-1:0] acc_o;

    logic [DW-1:0] mem [1 << AW];
    logic          ld_en = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [DW-1:0] ld_data = '0;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    acc_core #(.ADDR_W(AW)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .mem_addr_o  (mem_addr_o),
        .mem_rdata_i (mem_rdata_i),
        .mem_we_o    (mem_we_o),
        .mem_wdata_o (mem_wdata_o),
        .commit_o    (commit_o),
        .pc_o        (pc_o),
        .acc_o       (acc_o)
    );

    assign mem_rdata_i = mem[mem_addr_o];

    always @(posedge clk) begin
        if (ld_en)         mem[ld_addr] <= ld_data;
        else if (mem_we_o) mem[mem_addr_o] <= mem_wdata_o;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            fails = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<=100000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic load(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        ld_en = 1'b1; ld_addr = a; ld_data = d;
        @(posedge clk);
        #1 ld_en = 1'b0;
    endtask

    task automatic wait_commit(output int n);
        n = 0;
        do begin
            @(posedge clk);
            n++;
            #2;
        end while (!commit_o && n < 40);
        if (!commit_o) check("R10", "commit timeout", 0, 1);
    endtask

    function automatic string req_of(input logic [2:0] opc);
        case (opc)
            3'd0: return "R3";
            3'd1: return "R4";
            3'd2, 3'd3: return "R5";
            3'd4: return "R6";
            3'd5: return "R7";
            default: return "R8";
        endcase
    endfunction

    initial begin
        int n;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        // R1: reset state
        check("R1", "pc in reset", pc_o, 0);
        check("R1", "acc in reset", acc_o, 0);
        check("R1", "commit in reset", commit_o, 0);
        check("R1", "fetch address in reset", mem_addr_o, 0);

        // Vector table: word 0 loads the preset accumulator, word 1 is the test.
        for (int i = 0; i < NV; i++) begin
            logic [2:0] opc;
            string r;
            opc = VEC[i][46:44];
            r = req_of(opc);
            rst_n = 1'b0;
            load(5'd0, {3'd4, PRE});
            load(PRE, VEC[i][43:36]);
            load(5'd1, {opc, OPND});
            load(OPND, VEC[i][35:28]);
            @(negedge clk) rst_n = 1'b1;
            wait_commit(n);
            if (i == 0) check("R1", "first commit latency", n, 6);
            check("R6", "preset acc", acc_o, {24'd0, VEC[i][43:36]});
            check("R2", "pc after word 0", pc_o, 1);
            wait_commit(n);
            check(r, "latency", n, {28'd0, VEC[i][11:8]});
            check(r, "pc", pc_o, {24'd0, VEC[i][27:20]});
            check(r, "acc", acc_o, {24'd0, VEC[i][19:12]});
            check(r, "operand word", mem[OPND], {24'd0, VEC[i][7:0]});
        end

        // R9: every word is opcode 7; pc walks through the full range and wraps.
        rst_n = 1'b0;
        for (int a = 0; a < (1 << AW); a++) load(AW'(a), 8'hFF);
        @(negedge clk) rst_n = 1'b1;
        for (int k = 1; k <= 256; k++) begin
            wait_commit(n);
            if (k == 1) check("R8", "opcode 7 latency", n, 5);
            if (k == 133) begin
                check("R9", "pc mid walk", pc_o, 8'h85);
                check("R9", "fetch address low bits", mem_addr_o, 5'h05);
                @(posedge clk); #2;
                check("R10", "pulse one cycle", commit_o, 0);
                check("R10", "pc held after pulse", pc_o, 8'h85);
            end
            if (k == 255) check("R9", "pc at top", pc_o, 8'hFF);
            if (k == 256) check("R9", "pc wrapped", pc_o, 8'h00);
        end

        // R1: reset in mid-instruction restarts a fresh fetch at address 0.
        repeat (2) @(posedge clk);
        @(negedge clk) rst_n = 1'b0;
        @(posedge clk); #2;
        check("R1", "pc after mid reset", pc_o, 0);
        @(negedge clk) rst_n = 1'b1;
        wait_commit(n);
        check("R1", "latency after mid reset", n, 5);
        check("R1", "pc after restart", pc_o, 1);
        check("R1", "acc after restart", acc_o, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule